// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the command register of a two-bank parallel NOR flash. Each bus write arrives as one clock cycle with `wr_en` high, carrying a word address and a 16-bit data word. The decoder walks the multi-cycle unlock sequences and turns them into single-cycle operation requests: program, sector erase, chip erase, erase suspend and erase resume. Each request carries its target address and data. The block also keeps the current read-path mode: array, autoselect, query, hidden region or fast mode. While autoselect is active it answers identifier reads for the selected bank.

The array is split into two banks at the address `BANK_SPLIT`. Addresses at or above it belong to bank 1, the rest to bank 0. Commands look only at the low byte of the data word. Unlock comparisons look only at address bits 10 to 0. Per-bank busy flags from the embedded algorithm engine decide which commands are accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the mode output is array (0), `op_valid` is low and `id_valid` is low.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by a fourth write, issue one PROGRAM request (kind 1) with the fourth write's address and data. Only address bits 10:0 are compared during unlock.
- R3: The writes unlock, 80h@555h, unlock, then 30h to a sector address issue SECTOR_ERASE (kind 2) with that address. Each further 30h write queues another SECTOR_ERASE. If the final write is 10h@555h instead, the result is CHIP_ERASE (kind 3).
- R4: F0h written to any address in a sequence state, or in the autoselect, query or hidden mode, returns to array mode and issues nothing. The three-cycle form, unlock followed by F0h@555h, does the same.
- R5: Unlock followed by 90h@555h enters autoselect (mode 1) for the bank of that write. Reads in that bank at offset 00h return `MFR_CODE` and at offset 01h return `DEV_CODE`. Reads in the other bank give `id_valid` low.
- R6: Offsets 0Eh and 0Fh return `EXT_CODE1` and `EXT_CODE2` only when `DEV_CODE` equals 227Eh; otherwise those offsets are invalid.
- R7: A single write of B0h issues SUSPEND (kind 4) even when the addressed bank is busy. A single write of 30h in read mode issues RESUME (kind 5). Both carry the write address.
- R8: Unlock followed by 20h@555h enters fast mode (mode 4). In fast mode, A0h to any address followed by an address/data write issues PROGRAM. F0h alone does not leave fast mode. 90h followed by F0h or 00h returns to array mode.
- R9: Unlock followed by 88h@555h enters hidden mode (mode 3). 98h written at offset 55h (address bits 10:0) enters query mode (mode 2); 98h at any other offset is ignored.
- R10: A write that breaks an expected sequence returns to array mode without issuing a request.
- R11: While the addressed bank's `bank_busy` bit is set, an unlock start and a resume in read mode are ignored. The other bank still accepts them.
- R12: `op_valid` pulses for exactly one cycle, the cycle after the accepting write. Neither the mode nor a request changes without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle present this clock |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| bank_busy | input | 2 | Embedded operation running, one bit per bank |
| rd_addr | input | ADDR_W | Read address for identifier lookup |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | 16 | Program data of the request |
| mode_o | output | 3 | 0 array, 1 autoselect, 2 query, 3 hidden, 4 fast |
| id_valid | output | 1 | `rd_addr` hits an identifier location |
| id_data | output | 16 | Identifier word |

## Verification
The bench aims at the places where a sequence can go wrong partway through.

- A reset word or a wrong second unlock cycle arrives mid-sequence. A decoder that failed to fall back would issue a program on a later stray write.
- The erase queue receives a second sector. A decoder that left the queue state would drop that sector.
- F0h arrives in fast mode. A decoder that treated it like normal mode would fall out of fast mode.
- A busy bank receives a command. A decoder that checked the wrong bank would either block the idle bank or accept an unlock on the busy one.
- Identifier lookup uses the extended codes. A decoder that answered them whatever the device code was would be caught by a second instance whose device code differs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        MODE_ARRAY   = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_QUERY   = 3'd2,
        MODE_HIDDEN  = 3'd3,
        MODE_FAST    = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_SECT_ERASE = 3'd2,
        OP_CHIP_ERASE = 3'd3,
        OP_SUSPEND    = 3'd4,
        OP_RESUME     = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PRG,
        SQ_ERS_ARM,
        SQ_ERS_UNL1,
        SQ_ERS_UNL2,
        SQ_ERS_QUEUE,
        SQ_FAST,
        SQ_FAST_PRG,
        SQ_FAST_EXIT
    } seq_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_FAST    = 8'h20;
    localparam logic [7:0] CMD_HIDDEN  = 8'h88;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_ZERO    = 8'h00;

endpackage

// File: rtl/fcd_bank_sel.sv
module fcd_bank_sel #(
    parameter int unsigned          ADDR_W     = 21,
    parameter logic [ADDR_W-1:0]    BANK_SPLIT = 21'h1C0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank
);
    // Upper region (at or above the split point) is bank 1.
    assign bank = (addr >= BANK_SPLIT);
endmodule

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int unsigned       CMP_W     = 11,
    parameter logic [CMP_W-1:0]  KEY1_ADDR = 11'h555,
    parameter logic [CMP_W-1:0]  KEY2_ADDR = 11'h2AA,
    parameter logic [CMP_W-1:0]  QRY_ADDR  = 11'h055
) (
    input  logic [CMP_W-1:0] low_addr,
    output logic             hit_key1,
    output logic             hit_key2,
    output logic             hit_query
);
    assign hit_key1  = (low_addr == KEY1_ADDR);
    assign hit_key2  = (low_addr == KEY2_ADDR);
    assign hit_query = (low_addr == QRY_ADDR);
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
    parameter int unsigned       ADDR_W      = 21,
    parameter logic [ADDR_W-1:0] BANK_SPLIT  = 21'h1C0000,
    parameter logic [15:0]       MFR_CODE    = 16'h0004,
    parameter logic [15:0]       DEV_CODE    = 16'h227E,
    parameter logic [15:0]       EXT_CODE1   = 16'h2203,
    parameter logic [15:0]       EXT_CODE2   = 16'h2201,
    parameter logic [15:0]       EXT_TRIGGER = 16'h227E
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              active,
    input  logic              sel_bank,
    output logic              id_valid,
    output logic [15:0]       id_data
);
    logic       rd_bank;
    logic [7:0] offs;
    logic       hit;
    logic [15:0] word;

    fcd_bank_sel #(.ADDR_W(ADDR_W), .BANK_SPLIT(BANK_SPLIT)) bank_i (
        .addr (rd_addr),
        .bank (rd_bank)
    );

    assign offs = rd_addr[7:0];

    // The device code picks whether the extended identifier words exist.
    generate
        if (DEV_CODE == EXT_TRIGGER) begin : g_ext
            always_comb begin
                hit  = 1'b1;
                word = 16'h0000;
                case (offs)
                    8'h00:   word = MFR_CODE;
                    8'h01:   word = DEV_CODE;
                    8'h0E:   word = EXT_CODE1;
                    8'h0F:   word = EXT_CODE2;
                    default: hit  = 1'b0;
                endcase
            end
        end else begin : g_std
            always_comb begin
                hit  = 1'b1;
                word = 16'h0000;
                case (offs)
                    8'h00:   word = MFR_CODE;
                    8'h01:   word = DEV_CODE;
                    default: hit  = 1'b0;
                endcase
            end
        end
    endgenerate

    assign id_valid = active && (rd_bank == sel_bank) && hit;
    assign id_data  = id_valid ? word : 16'h0000;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 21,
    parameter logic [ADDR_W-1:0] BANK_SPLIT = 21'h1C0000,
    parameter logic [15:0]       MFR_CODE   = 16'h0004,
    parameter logic [15:0]       DEV_CODE   = 16'h227E,
    parameter logic [15:0]       EXT_CODE1  = 16'h2203,
    parameter logic [15:0]       EXT_CODE2  = 16'h2201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        bank_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [2:0]        mode_o,
    output logic              id_valid,
    output logic [15:0]       id_data
);
    localparam int unsigned CMP_W = 11;

    typedef struct packed {
        seq_e              seq;
        mode_e             mode;
        logic              id_bank;
        logic              op_valid;
        op_e               op_kind;
        logic [ADDR_W-1:0] op_addr;
        logic [15:0]       op_data;
    } state_t;

    state_t q, d;

    logic       w_bank, at_key1, at_key2, at_query, w_busy;
    logic [7:0] cmd;

    fcd_bank_sel #(.ADDR_W(ADDR_W), .BANK_SPLIT(BANK_SPLIT)) wbank_i (
        .addr (wr_addr),
        .bank (w_bank)
    );

    fcd_addr_match #(.CMP_W(CMP_W)) match_i (
        .low_addr  (wr_addr[CMP_W-1:0]),
        .hit_key1  (at_key1),
        .hit_key2  (at_key2),
        .hit_query (at_query)
    );

    assign cmd    = wr_data[7:0];
    assign w_busy = bank_busy[w_bank];

    always_comb begin
        d          = q;
        d.op_valid = 1'b0;
        d.op_kind  = OP_NONE;
        if (wr_en) begin
            case (q.seq)
                SQ_IDLE: begin
                    if (cmd == CMD_RESET) begin
                        d.mode = MODE_ARRAY;
                    end else if (cmd == CMD_SUSPEND) begin
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_SUSPEND;
                        d.op_addr  = wr_addr;
                    end else if (w_busy) begin
                        d.seq = SQ_IDLE;          // addressed bank busy: drop
                    end else if (cmd == CMD_KEY_A && at_key1) begin
                        d.seq = SQ_UNL1;
                    end else if (cmd == CMD_SECTOR) begin
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_RESUME;
                        d.op_addr  = wr_addr;
                    end else if (cmd == CMD_QUERY && at_query) begin
                        d.mode = MODE_QUERY;
                    end
                end
                SQ_UNL1: begin
                    if (cmd == CMD_KEY_B && at_key2) begin
                        d.seq = SQ_UNL2;
                    end else begin
                        d.seq  = SQ_IDLE;
                        d.mode = MODE_ARRAY;
                    end
                end
                SQ_UNL2: begin
                    d.seq  = SQ_IDLE;
                    d.mode = MODE_ARRAY;
                    if (at_key1) begin
                        case (cmd)
                            CMD_PROG: begin
                                d.seq  = SQ_PRG;
                                d.mode = q.mode;
                            end
                            CMD_ERASE: begin
                                d.seq  = SQ_ERS_ARM;
                                d.mode = q.mode;
                            end
                            CMD_IDENT: begin
                                d.mode    = MODE_AUTOSEL;
                                d.id_bank = w_bank;
                            end
                            CMD_FAST: begin
                                d.mode = MODE_FAST;
                                d.seq  = SQ_FAST;
                            end
                            CMD_HIDDEN: d.mode = MODE_HIDDEN;
                            default:    d.mode = MODE_ARRAY;
                        endcase
                    end
                end
                SQ_PRG: begin
                    d.seq      = SQ_IDLE;
                    d.op_valid = 1'b1;
                    d.op_kind  = OP_PROGRAM;
                    d.op_addr  = wr_addr;
                    d.op_data  = wr_data;
                end
                SQ_ERS_ARM: begin
                    if (cmd == CMD_KEY_A && at_key1) begin
                        d.seq = SQ_ERS_UNL1;
                    end else begin
                        d.seq  = SQ_IDLE;
                        d.mode = MODE_ARRAY;
                    end
                end
                SQ_ERS_UNL1: begin
                    if (cmd == CMD_KEY_B && at_key2) begin
                        d.seq = SQ_ERS_UNL2;
                    end else begin
                        d.seq  = SQ_IDLE;
                        d.mode = MODE_ARRAY;
                    end
                end
                SQ_ERS_UNL2, SQ_ERS_QUEUE: begin
                    if (q.seq == SQ_ERS_UNL2 && cmd == CMD_CHIP && at_key1) begin
                        d.seq      = SQ_IDLE;
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_CHIP_ERASE;
                        d.op_addr  = wr_addr;
                    end else if (cmd == CMD_SECTOR) begin
                        d.seq      = SQ_ERS_QUEUE;
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_SECT_ERASE;
                        d.op_addr  = wr_addr;
                    end else if (q.seq == SQ_ERS_QUEUE && cmd == CMD_SUSPEND) begin
                        d.seq      = SQ_IDLE;
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_SUSPEND;
                        d.op_addr  = wr_addr;
                    end else begin
                        d.seq  = SQ_IDLE;
                        d.mode = MODE_ARRAY;
                    end
                end
                SQ_FAST: begin
                    if (cmd == CMD_SUSPEND) begin
                        d.op_valid = 1'b1;
                        d.op_kind  = OP_SUSPEND;
                        d.op_addr  = wr_addr;
                    end else if (cmd == CMD_PROG && !w_busy) begin
                        d.seq = SQ_FAST_PRG;
                    end else if (cmd == CMD_IDENT) begin
                        d.seq = SQ_FAST_EXIT;
                    end
                end
                SQ_FAST_PRG: begin
                    d.seq      = SQ_FAST;
                    d.op_valid = 1'b1;
                    d.op_kind  = OP_PROGRAM;
                    d.op_addr  = wr_addr;
                    d.op_data  = wr_data;
                end
                SQ_FAST_EXIT: begin
                    if (cmd == CMD_RESET || cmd == CMD_ZERO) begin
                        d.seq  = SQ_IDLE;
                        d.mode = MODE_ARRAY;
                    end else begin
                        d.seq = SQ_FAST;
                    end
                end
                default: begin
                    d.seq  = SQ_IDLE;
                    d.mode = MODE_ARRAY;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.seq      <= SQ_IDLE;
            q.mode     <= MODE_ARRAY;
            q.id_bank  <= 1'b0;
            q.op_valid <= 1'b0;
            q.op_kind  <= OP_NONE;
            q.op_addr  <= '0;
            q.op_data  <= '0;
        end else begin
            q <= d;
        end
    end

    fcd_id_rom #(
        .ADDR_W     (ADDR_W),
        .BANK_SPLIT (BANK_SPLIT),
        .MFR_CODE   (MFR_CODE),
        .DEV_CODE   (DEV_CODE),
        .EXT_CODE1  (EXT_CODE1),
        .EXT_CODE2  (EXT_CODE2),
        .EXT_TRIGGER(16'h227E)
    ) id_i (
        .rd_addr  (rd_addr),
        .active   (q.mode == MODE_AUTOSEL),
        .sel_bank (q.id_bank),
        .id_valid (id_valid),
        .id_data  (id_data)
    );

    assign op_valid = q.op_valid;
    assign op_kind  = q.op_kind;
    assign op_addr  = q.op_addr;
    assign op_data  = q.op_data;
    assign mode_o   = q.mode;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [10:0] wr_low,
    input logic [7:0]  wr_cmd,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic [2:0]  mode_o,
    input logic        id_valid
);
    // R12: a request only follows an accepted write
    assert_op_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));

    // R12: a pulse always names an operation
    assert_op_kind_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind != 3'd0));

    // R12: mode holds across cycles without a write
    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_o));

    // R3: chip erase only from 10h written at 555h
    assert_chip_erase_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd3) |-> ($past(wr_low) == 11'h555 && $past(wr_cmd) == 8'h10));

    // R5: identifier readback only in autoselect
    assert_id_in_autosel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (mode_o == 3'd1));

    // R8: fast mode survives any write but F0h/00h
    assert_fast_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && wr_en && wr_cmd != 8'hF0 && wr_cmd != 8'h00) |=> (mode_o == 3'd4));
endmodule

bind flash_cmd_decoder fcd_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_low   (wr_addr[10:0]),
    .wr_cmd   (wr_data[7:0]),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .mode_o   (mode_o),
    .id_valid (id_valid)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [1:0]    bank_busy = 2'b00;
    logic [AW-1:0] rd_addr = '0;
    logic          op_valid, id_valid, alt_id_valid, alt_op_valid;
    logic [2:0]    op_kind, mode_o, alt_op_kind, alt_mode;
    logic [AW-1:0] op_addr, alt_op_addr;
    logic [15:0]   op_data, id_data, alt_op_data, alt_id_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bank_busy(bank_busy), .rd_addr(rd_addr), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .mode_o(mode_o), .id_valid(id_valid),
        .id_data(id_data)
    );

    flash_cmd_decoder #(.DEV_CODE(16'h2255)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bank_busy(bank_busy), .rd_addr(rd_addr), .op_valid(alt_op_valid), .op_kind(alt_op_kind),
        .op_addr(alt_op_addr), .op_data(alt_op_data), .mode_o(alt_mode), .id_valid(alt_id_valid),
        .id_data(alt_id_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] dt);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = dt;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock(input logic [AW-1:0] hi);
        wr(hi | 21'h555, 16'h00AA);
        wr(hi | 21'h2AA, 16'h0055);
    endtask

    task automatic expect_op(input string req, input logic [2:0] k,
                             input logic [AW-1:0] a, input logic [15:0] dt);
        chk({req, " op_valid"}, op_valid, 1'b1);
        chk({req, " op_kind"}, op_kind, k);
        chk({req, " op_addr"}, op_addr, a);
        if (k == 3'd1) chk({req, " op_data"}, op_data, dt);
    endtask

    task automatic expect_none(input string req);
        chk({req, " no request"}, op_valid, 1'b0);
    endtask

    task automatic t_reset_state;
        chk("R1 mode", mode_o, 3'd0);
        chk("R1 op_valid", op_valid, 1'b0);
        chk("R1 id_valid", id_valid, 1'b0);
    endtask

    task automatic t_program;
        unlock(21'h1F0000);            // high bits ignored
        expect_none("R2 after unlock");
        wr(21'h000555, 16'h00A0);
        expect_none("R2 after arm");
        wr(21'h012345, 16'hBEEF);
        expect_op("R2 program", 3'd1, 21'h012345, 16'hBEEF);
        @(negedge clk);
        chk("R12 pulse one cycle", op_valid, 1'b0);
    endtask

    task automatic t_erase;
        unlock(0); wr(21'h555, 16'h0080); unlock(0);
        wr(21'h040000, 16'h0030);
        expect_op("R3 sector erase", 3'd2, 21'h040000, 16'h0);
        wr(21'h080000, 16'h0030);
        expect_op("R3 queued sector", 3'd2, 21'h080000, 16'h0);
        wr(21'h000000, 16'h00F0);
        expect_none("R4 reset after queue");
        chk("R4 mode", mode_o, 3'd0);
        unlock(0); wr(21'h555, 16'h0080); unlock(0);
        wr(21'h000555, 16'h0010);
        expect_op("R3 chip erase", 3'd3, 21'h000555, 16'h0);
    endtask

    task automatic t_reset_forms;
        wr(21'h555, 16'h00AA);
        wr(21'h123456, 16'h00F0);
        expect_none("R4 reset mid unlock");
        wr(21'h2AA, 16'h0055); wr(21'h555, 16'h00A0);
        wr(21'h001000, 16'h1234);
        expect_none("R4 sequence cleared");
        unlock(0); wr(21'h555, 16'h00F0);
        chk("R4 three-cycle reset mode", mode_o, 3'd0);
        wr(21'h002000, 16'h5678);
        expect_none("R4 three-cycle reset no op");
    endtask

    task automatic t_autoselect;
        unlock(21'h1C0000); wr(21'h1C0555, 16'h0090);
        chk("R5 mode", mode_o, 3'd1);
        rd_addr = 21'h1C0000; #1;
        chk("R5 mfr valid", id_valid, 1'b1);
        chk("R5 mfr code", id_data, 16'h0004);
        rd_addr = 21'h1C0001; #1;
        chk("R5 device code", id_data, 16'h227E);
        rd_addr = 21'h1C000E; #1;
        chk("R6 ext1", id_data, 16'h2203);
        chk("R6 alt ext1 invalid", alt_id_valid, 1'b0);
        rd_addr = 21'h1C000F; #1;
        chk("R6 ext2", id_data, 16'h2201);
        rd_addr = 21'h1C0001; #1;
        chk("R6 alt device code", alt_id_data, 16'h2255);
        rd_addr = 21'h000001; #1;
        chk("R5 other bank invalid", id_valid, 1'b0);
        @(negedge clk);
        wr(21'h000000, 16'h00F0);
        chk("R4 leave autoselect", mode_o, 3'd0);
        rd_addr = 21'h1C0000; #1;
        chk("R4 id off", id_valid, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_busy_suspend;
        bank_busy = 2'b01;
        wr(21'h040000, 16'h00B0);
        expect_op("R7 suspend while busy", 3'd4, 21'h040000, 16'h0);
        unlock(0); wr(21'h555, 16'h00A0); wr(21'h003000, 16'h1111);
        expect_none("R11 busy bank unlock ignored");
        wr(21'h050000, 16'h0030);
        expect_none("R11 resume ignored while busy");
        unlock(21'h1C0000); wr(21'h1C0555, 16'h00A0); wr(21'h1C1000, 16'h2222);
        expect_op("R11 other bank accepted", 3'd1, 21'h1C1000, 16'h2222);
        bank_busy = 2'b00;
        wr(21'h040000, 16'h0030);
        expect_op("R7 resume", 3'd5, 21'h040000, 16'h0);
    endtask

    task automatic t_fast;
        unlock(0); wr(21'h555, 16'h0020);
        chk("R8 fast mode", mode_o, 3'd4);
        wr(21'h0ABCDE, 16'h00A0);
        expect_none("R8 fast arm");
        wr(21'h000123, 16'h5A5A);
        expect_op("R8 fast program", 3'd1, 21'h000123, 16'h5A5A);
        wr(21'h000000, 16'h00F0);
        chk("R8 F0 alone keeps fast", mode_o, 3'd4);
        wr(21'h000000, 16'h0090);
        chk("R8 exit step one", mode_o, 3'd4);
        wr(21'h000777, 16'h0000);
        chk("R8 exit complete", mode_o, 3'd0);
    endtask

    task automatic t_hidden_query;
        unlock(0); wr(21'h555, 16'h0088);
        chk("R9 hidden", mode_o, 3'd3);
        wr(21'h0, 16'h00F0);
        chk("R4 leave hidden", mode_o, 3'd0);
        wr(21'h000056, 16'h0098);
        chk("R9 query wrong offset", mode_o, 3'd0);
        wr(21'h000055, 16'h0098);
        chk("R9 query", mode_o, 3'd2);
        wr(21'h0, 16'h00F0);
        chk("R4 leave query", mode_o, 3'd0);
    endtask

    task automatic t_break;
        wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0056);
        wr(21'h555, 16'h00A0); wr(21'h004000, 16'h3333);
        expect_none("R10 bad second cycle");
        unlock(0); wr(21'h555, 16'h0088);
        wr(21'h555, 16'h00AA); wr(21'h2AB, 16'h0055);
        chk("R10 break leaves hidden", mode_o, 3'd0);
        unlock(0); wr(21'h555, 16'h0080); wr(21'h556, 16'h00AA);
        unlock(0); wr(21'h040000, 16'h0030);
        expect_none("R10 erase broken");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_erase();
        t_reset_forms();
        t_autoselect();
        t_busy_suspend();
        t_fast();
        t_hidden_query();
        t_break();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule